// File: doc/BRIEF.md
# Repeating Block Copy Sequencer

This block moves a run of bytes from one region of memory to another without help from the rest of the processor. It is loaded in one cycle with a source pointer, a destination pointer, a byte count and the current flag byte. After that it steps through the copy on its own. For each byte it reads the source location, writes that byte to the destination location, moves both pointers up by one and counts the remaining length down by one. It stops once the count reaches zero.

The memory side is a single synchronous port. A read issued in one cycle returns its data in the next cycle. The sequencer spends exactly one read cycle and one write cycle on each byte. For every byte it also reports the clock-state charge that the instruction-level timing model books for that pass: passes that loop back cost more than the last one. The updated flag byte and the final pointer and count values stay visible on the outputs after completion.

Top module: `blkcopy_engine`

## Requirements
- R1: After completion, every destination byte holds the value the source location held at the moment of its own copy. Bytes are moved one at a time in rising address order, so overlapping regions propagate earlier writes.
- R2: Each copied byte advances `src_out` and `dst_out` by one and lowers `cnt_out` by one.
- R3: The run ends after the pass that brings the count to zero. `done` is high for exactly one cycle, in the cycle after the final write, and `busy` is low from that cycle on.
- R4: A starting count of zero copies 2^CNT_W bytes, because the count is lowered before it is tested.
- R5: Both pointers and the count wrap modulo 2^ADDR_W and 2^CNT_W respectively.
- R6: In each write cycle `iter_pulse` is high. `iter_cost` then reads REPEAT_COST (21) if bytes remain after this one, and FINAL_COST (16) on the last byte.
- R7: Within the flag byte, bit 4 (half carry), bit 2 (parity/overflow) and bit 1 (add/subtract) are cleared. Bits 7, 6, 5, 3 and 0 keep the value given on `flags_in` at start.
- R8: Each byte takes two cycles. The read cycle has `mem_rd_en` high at the source address. The following write cycle has `mem_wr_en` high at the destination address. The two enables are never high together, so `busy` lasts exactly 2·n cycles for n bytes.
- R9: A `start` pulse while `busy` is high has no effect on the run in progress.
- R10: Out of reset, `busy`, `done`, `mem_rd_en`, `mem_wr_en`, `cnt_out` and `flags_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load the operands and begin when idle |
| src_in | input | ADDR_W | Starting source address |
| dst_in | input | ADDR_W | Starting destination address |
| cnt_in | input | CNT_W | Byte count (0 means 2^CNT_W) |
| flags_in | input | FLAG_W | Flag byte before the operation |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd_en | output | 1 | Memory read strobe, data returns next cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| iter_pulse | output | 1 | A byte is written in this cycle |
| iter_cost | output | COST_W | Clock-state charge of this pass |
| src_out | output | ADDR_W | Current source pointer |
| dst_out | output | ADDR_W | Current destination pointer |
| cnt_out | output | CNT_W | Remaining count |
| flags_out | output | FLAG_W | Updated flag byte |

## Verification
The bench uses 8-bit pointers and count and sweeps every starting count from 1 up to the zero-means-full case. Source and destination are spread across the space, so some runs are disjoint, some overlap forwards, some overlap backwards and some wrap past the top address. The overlapping runs separate a true byte-by-byte forward copy from a buffered one. The wrapping runs expose any missing modulo behaviour in the pointers. The full-length run shows whether zero is tested before or after the decrement. Flag inputs vary from run to run, so every kept bit and every cleared bit is seen at both values, and stray start pulses in the middle of longer runs show whether the sequencer re-latches its operands.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } bc_state_e;

   localparam int DEF_REPEAT_COST = 21;
   localparam int DEF_FINAL_COST  = 16;
   localparam logic [7:0] DEF_CLEAR_MASK = 8'b0001_0110;
endpackage

// File: rtl/blkcopy_ptrs.sv
module blkcopy_ptrs #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] src_in,
   input  logic [ADDR_W-1:0] dst_in,
   input  logic [CNT_W-1:0]  cnt_in,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              last
);
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         src_q <= src_in;
         dst_q <= dst_in;
         cnt_q <= cnt_in;
      end else if (step) begin
         src_q <= src_q + ADDR_ONE;
         dst_q <= dst_q + ADDR_ONE;
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign last = (cnt_q == CNT_ONE);
endmodule

// File: rtl/blkcopy_ctrl.sv
module blkcopy_ctrl
   import blkcopy_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic last,
   output logic load,
   output logic step,
   output logic rd_en,
   output logic wr_en,
   output logic busy,
   output logic done,
   output logic final_iter
);
   bc_state_e state_q, state_d;
   logic      done_q;

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      step    = 1'b0;
      rd_en   = 1'b0;
      wr_en   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               load    = 1'b1;
               state_d = ST_RD;
            end
         end
         ST_RD: begin
            rd_en   = 1'b1;
            state_d = ST_WR;
         end
         ST_WR: begin
            wr_en   = 1'b1;
            step    = 1'b1;
            state_d = last ? ST_IDLE : ST_RD;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == ST_WR) && last;
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;
   assign final_iter = (state_q == ST_WR) && last;
endmodule

// File: rtl/blkcopy_flagmask.sv
module blkcopy_flagmask #(
   parameter int               FLAG_W     = 8,
   parameter logic [FLAG_W-1:0] CLEAR_MASK = 8'b0001_0110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [FLAG_W-1:0] flags_q
);
   localparam logic [FLAG_W-1:0] KEEP_MASK = ~CLEAR_MASK;

   for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags_q[i] <= 1'b0;
         else if (load)
            flags_q[i] <= flags_in[i] & KEEP_MASK[i];
      end
   end
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
   import blkcopy_pkg::*;
#(
   parameter int               ADDR_W      = 16,
   parameter int               CNT_W       = 16,
   parameter int               DATA_W      = 8,
   parameter int               FLAG_W      = 8,
   parameter int               REPEAT_COST = DEF_REPEAT_COST,
   parameter int               FINAL_COST  = DEF_FINAL_COST,
   parameter logic [FLAG_W-1:0] CLEAR_MASK = DEF_CLEAR_MASK,
   localparam int              COST_W      = $clog2(REPEAT_COST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] src_in,
   input  logic [ADDR_W-1:0] dst_in,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              iter_pulse,
   output logic [COST_W-1:0] iter_cost,
   output logic [ADDR_W-1:0] src_out,
   output logic [ADDR_W-1:0] dst_out,
   output logic [CNT_W-1:0]  cnt_out,
   output logic [FLAG_W-1:0] flags_out
);
   initial begin
      assert (ADDR_W >= 2) else $error("ADDR_W too small");
      assert (CNT_W >= 2) else $error("CNT_W too small");
      assert (FINAL_COST < REPEAT_COST) else $error("final cost must be below repeat cost");
      assert (FINAL_COST > 0) else $error("final cost must be positive");
   end

   logic load, step, last, final_iter;

   blkcopy_ptrs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ptrs_i (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
      .src_q(src_out), .dst_q(dst_out), .cnt_q(cnt_out), .last(last)
   );

   blkcopy_ctrl ctrl_i (
      .clk(clk), .rst_n(rst_n), .start(start), .last(last),
      .load(load), .step(step), .rd_en(mem_rd_en), .wr_en(mem_wr_en),
      .busy(busy), .done(done), .final_iter(final_iter)
   );

   blkcopy_flagmask #(.FLAG_W(FLAG_W), .CLEAR_MASK(CLEAR_MASK)) flags_i (
      .clk(clk), .rst_n(rst_n), .load(load),
      .flags_in(flags_in), .flags_q(flags_out)
   );

   assign mem_addr   = mem_wr_en ? dst_out : src_out;
   assign mem_wdata  = mem_rdata;
   assign iter_pulse = step;
   assign iter_cost  = !step      ? '0 :
                       final_iter ? COST_W'(FINAL_COST) : COST_W'(REPEAT_COST);
endmodule

module blkcopy_engine_chk #(
   parameter int               ADDR_W      = 16,
   parameter int               CNT_W       = 16,
   parameter int               FLAG_W      = 8,
   parameter int               REPEAT_COST = 21,
   parameter int               FINAL_COST  = 16,
   parameter logic [FLAG_W-1:0] CLEAR_MASK = 8'b0001_0110,
   parameter int               COST_W      = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd_en,
   input logic              mem_wr_en,
   input logic              busy,
   input logic              done,
   input logic              iter_pulse,
   input logic [COST_W-1:0] iter_cost,
   input logic [ADDR_W-1:0] src_out,
   input logic [ADDR_W-1:0] dst_out,
   input logic [CNT_W-1:0]  cnt_out,
   input logic [FLAG_W-1:0] flags_out
);
   assert_rw_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));
   assert_write_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> mem_wr_en);
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd_en && !mem_wr_en));
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      iter_pulse |=> cnt_out == CNT_W'($past(cnt_out) - CNT_W'(1)));
   assert_src_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      iter_pulse |=> src_out == ADDR_W'($past(src_out) + ADDR_W'(1)));
   assert_dst_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      iter_pulse |=> dst_out == ADDR_W'($past(dst_out) + ADDR_W'(1)));
   assert_repeat_cost_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (iter_pulse && iter_cost == COST_W'(REPEAT_COST)) |=> (busy && !done));
   assert_final_cost_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (iter_pulse && iter_cost == COST_W'(FINAL_COST)) |=> (done && !busy));
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_out & CLEAR_MASK) == '0);
endmodule

bind blkcopy_engine blkcopy_engine_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FLAG_W(FLAG_W),
   .REPEAT_COST(REPEAT_COST), .FINAL_COST(FINAL_COST),
   .CLEAR_MASK(CLEAR_MASK), .COST_W(COST_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
   .busy(busy), .done(done), .iter_pulse(iter_pulse), .iter_cost(iter_cost),
   .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out), .flags_out(flags_out)
);

// File: tb/blkcopy_engine_tb_top.sv
module blkcopy_engine_tb_top;
   localparam int AW = 8;
   localparam int CW = 8;
   localparam int DW = 8;
   localparam int FW = 8;
   localparam int NMEM = 1 << AW;
   localparam int CSTW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] src_in = '0, dst_in = '0;
   logic [CW-1:0] cnt_in = '0;
   logic [FW-1:0] flags_in = '0;
   logic [AW-1:0] mem_addr;
   logic          mem_rd_en, mem_wr_en;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          busy, done, iter_pulse;
   logic [CSTW-1:0] iter_cost;
   logic [AW-1:0] src_out, dst_out;
   logic [CW-1:0] cnt_out;
   logic [FW-1:0] flags_out;

   logic [DW-1:0] mem [NMEM];
   logic [DW-1:0] ref_mem [NMEM];

   int checks = 0, fails = 0, cyc = 0;
   int busy_cyc = 0, rep_cnt = 0, fin_cnt = 0, bad_cost = 0, done_cnt = 0;
   int bad_rd = 0, bad_wr = 0;
   logic [AW-1:0] exp_rd_addr = '0, exp_wr_addr = '0;
   bit summary_done = 1'b0;

   always #5 clk = ~clk;

   blkcopy_engine #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW), .FLAG_W(FW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .flags_in(flags_in),
      .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .iter_pulse(iter_pulse), .iter_cost(iter_cost),
      .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out), .flags_out(flags_out)
   );

   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr];
      if (mem_wr_en) mem[mem_addr] <= mem_wdata;
   end

   // observer: counts busy cycles, pass charges and memory addressing
   always @(negedge clk) begin
      if (busy) busy_cyc <= busy_cyc + 1;
      if (done) done_cnt <= done_cnt + 1;
      if (mem_rd_en && mem_addr != exp_rd_addr) bad_rd <= bad_rd + 1;
      if (mem_rd_en) exp_rd_addr <= exp_rd_addr + 1'b1;
      if (mem_wr_en && mem_addr != exp_wr_addr) bad_wr <= bad_wr + 1;
      if (mem_wr_en) exp_wr_addr <= exp_wr_addr + 1'b1;
      if (iter_pulse) begin
         if (iter_cost == CSTW'(21)) rep_cnt <= rep_cnt + 1;
         else if (iter_cost == CSTW'(16)) fin_cnt <= fin_cnt + 1;
         else bad_cost <= bad_cost + 1;
      end
   end

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         fails = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog: act=%0d cycles exp=<190000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_copy(input logic [AW-1:0] s, input logic [AW-1:0] d,
                           input logic [CW-1:0] c, input logic [FW-1:0] f,
                           input bit poke);
      int n;
      int mism;
      int first_bad;
      int guard;
      n = (c == '0) ? (1 << CW) : int'(c);
      for (int i = 0; i < NMEM; i++) ref_mem[i] = mem[i];
      for (int i = 0; i < n; i++)
         ref_mem[(int'(d) + i) % NMEM] = ref_mem[(int'(s) + i) % NMEM];
      @(negedge clk);
      busy_cyc = 0; rep_cnt = 0; fin_cnt = 0; bad_cost = 0; done_cnt = 0;
      bad_rd = 0; bad_wr = 0; exp_rd_addr = s; exp_wr_addr = d;
      src_in = s; dst_in = d; cnt_in = c; flags_in = f; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         @(negedge clk);
         src_in = ~s; dst_in = ~d; cnt_in = c + 8'd3; flags_in = ~f; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 2 * n + 10) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
      mism = 0; first_bad = -1;
      for (int i = 0; i < NMEM; i++)
         if (mem[i] !== ref_mem[i]) begin
            mism++;
            if (first_bad < 0) first_bad = i;
         end
      chk(mism == 0, "R1", "memory mismatches", mism, 0);
      chk(src_out == AW'(int'(s) + n), "R2 R5", "final src", src_out, AW'(int'(s) + n));
      chk(dst_out == AW'(int'(d) + n), "R2 R5", "final dst", dst_out, AW'(int'(d) + n));
      chk(cnt_out == '0, "R3 R4", "final count", cnt_out, 0);
      chk(done_cnt == 1 && !busy, "R3", "done pulses", done_cnt, 1);
      chk(busy_cyc == 2 * n, poke ? "R8 R9" : "R8", "busy cycles", busy_cyc, 2 * n);
      chk(bad_rd == 0 && bad_wr == 0, "R8", "address errors", bad_rd + bad_wr, 0);
      chk(rep_cnt == n - 1 && bad_cost == 0, "R6", "repeat passes", rep_cnt, n - 1);
      chk(fin_cnt == 1, "R6", "final passes", fin_cnt, 1);
      chk(flags_out == (f & 8'hE9), "R7", "flags", flags_out, f & 8'hE9);
   endtask

   initial begin
      for (int i = 0; i < NMEM; i++) mem[i] = DW'(i * 7 + 3);
      repeat (3) @(negedge clk);
      chk(!busy && !done, "R10", "busy/done after reset", {busy, done}, 0);
      chk(!mem_rd_en && !mem_wr_en, "R10", "mem strobes after reset", {mem_rd_en, mem_wr_en}, 0);
      chk(cnt_out == '0 && flags_out == '0, "R10", "count/flags after reset", cnt_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_rd_en, "R10", "idle after reset release", busy, 0);
      // full-range sweep: count 256 is given as 0 (R4), offsets chosen to mix overlap and wrap (R5)
      for (int k = 1; k <= (1 << CW); k++) begin
         run_copy(AW'(k * 37), AW'(k * 91 + 5), CW'(k), FW'(k * 13) ^ 8'hA5, k >= 4);
         for (int i = 0; i < NMEM; i++) if ((i + k) % 5 == 0) mem[i] = DW'(i ^ k);
      end
      // forward overlap by one byte: fill from a single value (R1)
      run_copy(8'd10, 8'd11, 8'd20, 8'hFF, 1'b0);
      run_copy(8'd11, 8'd10, 8'd20, 8'h00, 1'b0);
      // wrap across the top of the space (R5)
      run_copy(8'd250, 8'd252, 8'd12, 8'h16, 1'b0);
      summary();
      $finish;
   end
endmodule